// File: doc/BRIEF.md
# Receive Clock Delay Line Calibration Tuner

This block calibrates a tapped delay line that sits in a card receive clock path, then selects the tap at which data is sampled. Calibration has two steps. The unit search walks the per-cell unit delay upward from zero until the line reports a measured length that fits inside one clock period. The phase scan then walks the tap select from zero to the highest usable tap. At each tap it asks an outside agent to run one tuning transfer and records whether the transfer passed. The chosen tap is the middle of the longest unbroken run of passing taps.

The delay line is reached through a register-like port. A two-bit control word carries enable in bit 0 and sampler enable in bit 1, and a control value of zero bypasses the line. A 32-bit configuration word carries the tap select in bits 3:0 and the unit delay in bits 14:8. A one-cycle load strobe marks each new setting. The line answers with a 32-bit status word that carries the measured length in bits 27:16 and a length-valid flag in bit 31. Timeouts are counted in pulses of a 1 µs tick input.

The tuning transfer uses a request/acknowledge handshake. `test_req_o` acts as valid and `test_ack_i` as ready. Once raised, the request and the tap select stay unchanged until the agent acknowledges, so the agent may stall for as long as it needs. The pass/fail result is taken only in the cycle where request and acknowledge are both high. A `start_i` pulse is taken only while no calibration is running.

Top module: `dlycal_tuner`

## Requirements
- R1: After reset, `done_o`, `err_o` and `test_req_o` are low and the control word is 0 (line bypassed).
- R2: During the unit search every load presents control 2'b11 and select NB_CELLS+1 (12 by default). The unit field is 0 on the first load and grows by exactly one on each following load.
- R3: If length-valid (status bit 31) does not arrive within TIMEOUT_TICKS tick pulses after a load, the search moves to the next unit. With the tick held high, consecutive loads are then TIMEOUT_TICKS+1 cycles apart.
- R4: The first unit whose valid length (status bits 27:16) is nonzero and below 2^NB_CELLS is accepted. Zero lengths and lengths of 2^NB_CELLS or more are passed over.
- R5: If no unit up to 127 qualifies, `err_o` rises, no tuning transfer is requested, and the line is left bypassed.
- R6: The highest tap scanned is the bit index of the most significant set bit of the accepted length. Taps 0 to that index are each tested once, in ascending order, with control 2'b01.
- R7: A raised `test_req_o` holds, with an unchanged select, until `test_ack_i`. The pass flag is used only in the acknowledge cycle.
- R8: The chosen phase is the end tap of the longest passing run minus half that run length, rounded down. On a tie in length, the earlier run wins.
- R9: If no tap passes, `err_o` rises and the line is left bypassed.
- R10: After the scan and before the final setting, the control word is 0 for at least one cycle. With `done_o` the line holds control 2'b01, select equal to `phase_o` and unit equal to `unit_o`. `done_o` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin calibration (pulse; ignored while running) |
| tick_i | input | 1 | 1 µs timeout tick |
| done_o | output | 1 | Calibration finished with a usable phase |
| err_o | output | 1 | Calibration failed |
| unit_o | output | 7 | Accepted unit delay |
| phase_o | output | 4 | Chosen tap |
| dl_ctrl_o | output | 2 | Line control: bit 0 enable, bit 1 sampler |
| dl_cfg_o | output | 32 | Line config: select 3:0, unit 14:8 |
| dl_load_o | output | 1 | One-cycle strobe: new control/config presented |
| dl_stat_i | input | 32 | Line status: length 27:16, length-valid 31 |
| test_req_o | output | 1 | Tuning transfer request (valid) |
| test_ack_i | input | 1 | Transfer finished (ready) |
| test_pass_i | input | 1 | Transfer result, sampled with acknowledge |

## Verification
The bench builds the block with the default 11 cells and with TIMEOUT_TICKS set to 4, holding the tick high. A timed-out unit then costs five cycles, so a sweep of all 128 units that finds no valid length stays short. Accepted lengths are chosen so that the highest usable tap lands at 0, 5, 7 and 10. The model of the line can answer with zero, with an oversize length, or not at all, and the agent stalls every acknowledge, which exercises the handshake hold.

// File: rtl/dlycal_pkg.sv
package dlycal_pkg;
  localparam int SEL_W    = 4;
  localparam int UNIT_W   = 7;
  localparam int LEN_W    = 12;
  localparam int SEL_LSB  = 0;
  localparam int UNIT_LSB = 8;
  localparam int LEN_LSB  = 16;
  localparam int LENV_BIT = 31;

  typedef struct packed {
    logic              en;
    logic              samp;
    logic [SEL_W-1:0]  sel;
    logic [UNIT_W-1:0] unit;
    logic              load;
  } dl_drive_t;

  function automatic logic [SEL_W-1:0] top_bit(input logic [LEN_W-1:0] v);
    logic [SEL_W-1:0] r;
    r = '0;
    for (int i = 0; i < LEN_W; i++)
      if (v[i]) r = SEL_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/dlycal_unit_search.sv
module dlycal_unit_search
  import dlycal_pkg::*;
#(
  parameter int NB_CELLS      = 11,
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              len_vld_i,
  output dl_drive_t         drv_o,
  output logic              busy_o,
  output logic              ok_o,
  output logic              fail_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic [SEL_W-1:0]  maxph_o
);
  localparam int CW        = $clog2(TIMEOUT_TICKS + 1);
  localparam int UNIT_MAX  = (1 << UNIT_W) - 1;
  localparam int LEN_LIMIT = 1 << NB_CELLS;

  typedef enum logic [1:0] {C_IDLE, C_LOAD, C_WAIT} cst_e;
  cst_e st;
  logic [CW-1:0]     cnt;
  logic [UNIT_W-1:0] unit_q;
  logic              len_good;

  assign len_good = (len_i != '0) && (len_i < LEN_W'(LEN_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= C_IDLE;
      cnt     <= '0;
      unit_q  <= '0;
      maxph_o <= '0;
      ok_o    <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
      case (st)
        C_IDLE: if (start_i) begin
          unit_q <= '0;
          st     <= C_LOAD;
        end
        C_LOAD: begin
          cnt <= '0;
          st  <= C_WAIT;
        end
        default: begin
          if (len_vld_i && len_good) begin
            maxph_o <= top_bit(len_i);
            ok_o    <= 1'b1;
            st      <= C_IDLE;
          end else if (len_vld_i || (tick_i && cnt == CW'(TIMEOUT_TICKS - 1))) begin
            if (unit_q == UNIT_W'(UNIT_MAX)) begin
              fail_o <= 1'b1;
              st     <= C_IDLE;
            end else begin
              unit_q <= unit_q + 1'b1;
              st     <= C_LOAD;
            end
          end else if (tick_i) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    drv_o.en   = (st != C_IDLE);
    drv_o.samp = (st != C_IDLE);
    drv_o.sel  = SEL_W'(NB_CELLS + 1);
    drv_o.unit = unit_q;
    drv_o.load = (st == C_LOAD);
  end
  assign busy_o = (st != C_IDLE);
  assign unit_o = unit_q;

  // R3
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(TIMEOUT_TICKS));
  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_LOAD && $past(st) == C_WAIT) |-> unit_q == $past(unit_q) + 1'b1);
endmodule

// File: rtl/dlycal_phase_scan.sv
module dlycal_phase_scan
  import dlycal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic [SEL_W-1:0]  maxph_i,
  output logic              test_req_o,
  input  logic              test_ack_i,
  input  logic              test_pass_i,
  output dl_drive_t         drv_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [SEL_W-1:0]  phase_o
);
  localparam int RW = SEL_W + 1;

  typedef enum logic [2:0] {P_IDLE, P_LOAD, P_REQ, P_DECIDE, P_FINAL, P_HOLD} pst_e;
  pst_e st;
  logic [SEL_W-1:0] ph, best_end, fin_ph;
  logic [RW-1:0]    cur, best, cur_nx;

  assign cur_nx = test_pass_i ? cur + 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      ph       <= '0;
      cur      <= '0;
      best     <= '0;
      best_end <= '0;
      fin_ph   <= '0;
      done_o   <= 1'b0;
      fail_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      case (st)
        P_IDLE, P_HOLD: begin
          if (start_i) begin
            ph       <= '0;
            cur      <= '0;
            best     <= '0;
            best_end <= '0;
            st       <= P_LOAD;
          end else if (abort_i) begin
            st <= P_IDLE;
          end
        end
        P_LOAD: st <= P_REQ;
        P_REQ: if (test_ack_i) begin
          cur <= cur_nx;
          if (cur_nx > best) begin
            best     <= cur_nx;
            best_end <= ph;
          end
          if (ph == maxph_i) st <= P_DECIDE;
          else begin
            ph <= ph + 1'b1;
            st <= P_LOAD;
          end
        end
        P_DECIDE: begin
          if (best == '0) begin
            fail_o <= 1'b1;
            st     <= P_IDLE;
          end else begin
            fin_ph <= best_end - SEL_W'(best >> 1);
            st     <= P_FINAL;
          end
        end
        P_FINAL: begin
          done_o <= 1'b1;
          st     <= P_HOLD;
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  always_comb begin
    drv_o.en   = (st == P_LOAD) || (st == P_REQ) || (st == P_FINAL) || (st == P_HOLD);
    drv_o.samp = 1'b0;
    drv_o.sel  = (st == P_FINAL || st == P_HOLD) ? fin_ph : ph;
    drv_o.unit = unit_i;
    drv_o.load = (st == P_LOAD) || (st == P_FINAL);
  end
  assign test_req_o = (st == P_REQ);
  assign busy_o     = (st != P_IDLE) && (st != P_HOLD);
  assign phase_o    = fin_ph;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_o && !test_ack_i) |=> (test_req_o && ph == $past(ph)));
  // R6
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o |-> ph <= maxph_i);
endmodule

// File: rtl/dlycal_tuner.sv
module dlycal_tuner
  import dlycal_pkg::*;
#(
  parameter int NB_CELLS      = 11,
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              done_o,
  output logic              err_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic [SEL_W-1:0]  phase_o,
  output logic [1:0]        dl_ctrl_o,
  output logic [31:0]       dl_cfg_o,
  output logic              dl_load_o,
  input  logic [31:0]       dl_stat_i,
  output logic              test_req_o,
  input  logic              test_ack_i,
  input  logic              test_pass_i
);
  dl_drive_t         cal_drv, scan_drv, drv;
  logic              cal_busy, cal_ok, cal_fail;
  logic              scan_busy, scan_done, scan_fail;
  logic [SEL_W-1:0]  maxph;
  logic              scan_mode, go;
  logic [LEN_W-1:0]  st_len;
  logic              st_vld;
  logic              unused_stat;

  assign st_len      = dl_stat_i[LEN_LSB +: LEN_W];
  assign st_vld      = dl_stat_i[LENV_BIT];
  assign unused_stat = ^{dl_stat_i[LEN_LSB-1:0], dl_stat_i[LENV_BIT-1:LEN_LSB+LEN_W]};
  assign go          = start_i && !cal_busy && !scan_busy;

  dlycal_unit_search #(.NB_CELLS(NB_CELLS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_search (
    .clk(clk), .rst_n(rst_n), .start_i(go), .tick_i(tick_i),
    .len_i(st_len), .len_vld_i(st_vld), .drv_o(cal_drv), .busy_o(cal_busy),
    .ok_o(cal_ok), .fail_o(cal_fail), .unit_o(unit_o), .maxph_o(maxph));

  dlycal_phase_scan u_scan (
    .clk(clk), .rst_n(rst_n), .start_i(cal_ok), .abort_i(go),
    .unit_i(unit_o), .maxph_i(maxph), .test_req_o(test_req_o),
    .test_ack_i(test_ack_i), .test_pass_i(test_pass_i), .drv_o(scan_drv),
    .busy_o(scan_busy), .done_o(scan_done), .fail_o(scan_fail), .phase_o(phase_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      scan_mode <= 1'b0;
    end else if (go) begin
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      scan_mode <= 1'b0;
    end else begin
      if (cal_ok) scan_mode <= 1'b1;
      if (cal_fail || scan_fail) err_o <= 1'b1;
      if (scan_done) done_o <= 1'b1;
    end
  end

  assign drv = scan_mode ? scan_drv : cal_drv;

  always_comb begin
    dl_cfg_o                      = '0;
    dl_cfg_o[SEL_LSB +: SEL_W]    = drv.sel;
    dl_cfg_o[UNIT_LSB +: UNIT_W]  = drv.unit;
    dl_ctrl_o                     = {drv.samp, drv.en};
    dl_load_o                     = drv.load;
  end

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R6
  scan_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o |-> dl_ctrl_o == 2'b01);
  // R10
  final_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (dl_ctrl_o == 2'b01 && dl_cfg_o[SEL_LSB +: SEL_W] == phase_o
                       && dl_cfg_o[UNIT_LSB +: UNIT_W] == unit_o));
  // R9
  err_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> dl_ctrl_o == 2'b00);
endmodule

// File: tb/test_dlycal_tuner.sv
module test_dlycal_tuner;
  localparam int TO = 4;

  typedef struct packed {
    logic [7:0]  acc;
    logic [1:0]  mode;
    logic [11:0] lng;
    logic [11:0] mask;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'd5,   2'd2, 12'h0F0, 12'h03C},
    '{8'd0,   2'd0, 12'h001, 12'h001},
    '{8'd127, 2'd1, 12'h7FF, 12'h773},
    '{8'd128, 2'd0, 12'h000, 12'h000},
    '{8'd10,  2'd2, 12'h020, 12'h000},
    '{8'd3,   2'd1, 12'h03F, 12'h03F}
  };

  logic clk = 0, rst_n = 0, start = 0, tick = 1;
  logic done, err, dl_load, test_req;
  logic [6:0]  unit;
  logic [3:0]  phase;
  logic [1:0]  dl_ctrl;
  logic [31:0] dl_cfg;
  logic        stat_vld = 0;
  logic [11:0] stat_len = 0;
  logic        ack = 0, pass = 0;

  always #4 clk = ~clk;

  dlycal_tuner #(.NB_CELLS(11), .TIMEOUT_TICKS(TO)) i_dlycal_tuner (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
    .done_o(done), .err_o(err), .unit_o(unit), .phase_o(phase),
    .dl_ctrl_o(dl_ctrl), .dl_cfg_o(dl_cfg), .dl_load_o(dl_load),
    .dl_stat_i({stat_vld, 3'b0, stat_len, 16'h0}),
    .test_req_o(test_req), .test_ack_i(ack), .test_pass_i(pass));

  int checks = 0, errors = 0;
  int cyc = 0, pend = 0, wait_n = 0, last_load = -1, exp_unit = 0;
  int cal_cfg_err = 0, unit_seq_err = 0, gap_err = 0, gap_seen = 0;
  int hs_err = 0, order_err = 0, n_tests = 0;
  bit byp_seen = 0, cur_samp = 0, req_prev = 0;
  logic [3:0]  sel_prev = 0;
  int          cur_unit = 0;
  vec_t        cv = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural delay line and tuning agent
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      stat_vld = 0; ack = 0; pend = 0;
    end else begin
      if (dl_load) begin
        stat_vld = 0; pend = 2; cur_unit = int'(dl_cfg[14:8]); cur_samp = dl_ctrl[1];
        if (dl_ctrl[1]) begin
          if (dl_cfg[3:0] != 4'd12 || dl_ctrl != 2'b11) cal_cfg_err++;
          if (cur_unit != exp_unit) unit_seq_err++;
          exp_unit = cur_unit + 1;
          if (last_load >= 0 && cv.mode == 2) begin
            gap_seen++;
            if (cyc - last_load != TO + 1) gap_err++;
          end
          last_load = cyc;
        end
      end else if (pend > 0) begin
        pend--;
        if (pend == 0 && cur_samp) begin
          if (cur_unit == int'(cv.acc)) begin stat_vld = 1; stat_len = cv.lng; end
          else if (cv.mode == 0) begin stat_vld = 1; stat_len = 12'h000; end
          else if (cv.mode == 1) begin stat_vld = 1; stat_len = 12'h800; end
        end
      end
      if (ack) ack = 0;
      else if (test_req) begin
        if (req_prev && dl_cfg[3:0] != sel_prev) hs_err++;
        wait_n++;
        if (wait_n == 3) begin
          ack = 1; pass = cv.mask[dl_cfg[3:0]];
          if (int'(dl_cfg[3:0]) != n_tests) order_err++;
          n_tests++; wait_n = 0;
        end
      end
      req_prev = test_req; sel_prev = dl_cfg[3:0];
      if (n_tests > 0 && !dl_ctrl[0] && !done) byp_seen = 1;
    end
  end

  function automatic int msb_of(input logic [11:0] v);
    int r = 0;
    for (int i = 0; i < 12; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic run_vec(input int k);
    bit e_err; int e_phase, e_tests, mp, cur, best, bend, wd;
    vec_t v = VEC[k];
    e_phase = 0; e_err = 0; e_tests = 0;
    if (v.acc > 127) e_err = 1;
    else begin
      mp = msb_of(v.lng); e_tests = mp + 1; cur = 0; best = 0; bend = 0;
      for (int p = 0; p <= mp; p++) begin
        if (v.mask[p]) begin
          cur++;
          if (cur > best) begin best = cur; bend = p; end
        end else cur = 0;
      end
      if (best == 0) e_err = 1; else e_phase = bend - best / 2;
    end
    @(posedge clk); #1;
    cv = v; exp_unit = 0; last_load = -1; n_tests = 0; byp_seen = 0;
    cal_cfg_err = 0; unit_seq_err = 0; gap_err = 0; gap_seen = 0; hs_err = 0; order_err = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    wd = 0;
    while (!done && !err && wd < 20000) begin @(negedge clk); wd++; end
    chk(wd < 20000, "R1 watchdog", wd, 20000);
    chk(err == e_err, "R5/R9 error outcome", err, e_err);
    chk(cal_cfg_err == 0, "R2 search config", cal_cfg_err, 0);
    chk(unit_seq_err == 0, "R2 unit order", unit_seq_err, 0);
    chk(n_tests == e_tests, "R6 test count", n_tests, e_tests);
    chk(order_err == 0, "R6 tap order", order_err, 0);
    chk(hs_err == 0, "R7 request hold", hs_err, 0);
    if (v.mode == 2 && v.acc > 0) chk(gap_seen > 0 && gap_err == 0, "R3 timeout spacing", gap_err, 0);
    if (!e_err) begin
      chk(int'(unit) == int'(v.acc), "R4 accepted unit", unit, v.acc);
      chk(int'(phase) == e_phase, "R8 chosen phase", phase, e_phase);
      chk(byp_seen, "R10 bypass before final", byp_seen, 1);
      chk(dl_ctrl == 2'b01 && dl_cfg[3:0] == phase && dl_cfg[14:8] == unit,
          "R10 final line setting", dl_ctrl, 1);
      repeat (20) @(negedge clk);
      chk(done == 1'b1, "R10 done held", done, 1);
    end else begin
      chk(dl_ctrl == 2'b00, "R5/R9 bypass on error", dl_ctrl, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && err == 0 && test_req == 0 && dl_ctrl == 2'b00, "R1 reset state",
        {done, err, test_req, dl_ctrl}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(dl_ctrl == 2'b00 && !done && !err, "R1 idle after reset", dl_ctrl, 0);
    for (int k = 0; k < 6; k++) run_vec(k);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL R1 watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule